// File: doc/BRIEF.md
# Dual-Bank Edge/Level Interrupt Controller

This block collects 64 interrupt request lines into two banks of 32 bits each and reduces them to a single interrupt output for one CPU. Each bank keeps three registers: latched events, an enable mask and the live input levels. A fixed per-bit parameter chooses whether a line is edge-triggered or level-triggered. An edge-triggered line latches an event on its rising edge, and software must acknowledge that event. A level-triggered line never latches. It requests service for as long as its input stays high.

Software reaches the banks through a plain 32-bit register port that has an address, a write strobe, write data and combinational read data. It can read events, mask and levels, write the mask, and clear events by writing ones to an acknowledge location. The line numbering is reversed with respect to the banks: lines 0..31 feed the upper bank and lines 32..63 feed the lower bank. The CPU output is registered.

Top module: `irqc_dual_bank`

## Requirements
- R1: After reset, the events, mask and levels registers of both banks read as zero and `cpu_irq` is low.
- R2: The bank index is (reg_addr[11:0] − 0x10) >> 4, computed modulo 4096. Within a bank, reg_addr[3:0] selects the register: 0x0 reads events, 0x4 reads and writes the mask, 0x8 is the write-only acknowledge, and 0xC reads levels. With two banks, bank 0 occupies 0x10–0x1F and bank 1 occupies 0x20–0x2F.
- R3: A bank index of 2 or more, or any low nibble other than 0x0, 0x4, 0x8 or 0xC, reads as zero, and writes to it change nothing. Reads of 0x8 also return zero, and writes to 0x0 or 0xC change nothing.
- R4: Input line k feeds bank 1 − (k >> 5) at bit k & 31.
- R5: At each clock edge, a bank's levels register takes the sampled value of its input lines.
- R6: An edge-triggered line sets its event bit when it is sampled high after being sampled low. Its event bit is not cleared when the line falls. A line held high does not set its event again after an acknowledge.
- R7: Level-triggered lines are bank 0 bits none and bank 1 bits 20..28 (selection 0x00000000 and 0x1FF00000). Their event bits never set and an acknowledge does not affect them. They contribute to pending through their live level.
- R8: A write of value V to a bank's acknowledge location clears every event bit that is 1 in V. All other event bits are left as they were.
- R9: If a rising edge on an edge-triggered line arrives at the same clock edge as an acknowledge of that bit, the event bit ends up set.
- R10: Bank pending is (events | (levels & level_select)) & mask. `cpu_irq` is high when either bank has a pending bit. It is registered and takes the value for the register state produced by the same clock edge, so it reflects an input, mask or acknowledge change one clock after that change.
- R11: A write to the mask location stores the written word, and a read of that location returns it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 64 | Interrupt request lines, numbered 0..63 |
| reg_addr | input | 12 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
The bench builds the block with its default parameters: two banks of 32 bits and the level selection 0x00000000 / 0x1FF00000. These values bring the full 64-line reversed mapping and the band of level-triggered lines inside bank 1 within reach. They also make the address wrap reachable: addresses below 0x10 and from 0x30 upward decode as out of range. Directed phases cover held lines across an acknowledge, an edge that coincides with an acknowledge, and a level line with acknowledge writes aimed at it. A long random phase then drives mixed line toggles and writes across in-range, unused and out-of-range addresses.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned WIN_W  = 12;
  localparam int unsigned IDX_W  = 8;
  localparam logic [WIN_W-1:0] WIN_BASE = 12'h010;

  typedef enum logic [1:0] {
    SEL_EVENTS,
    SEL_MASK,
    SEL_ACK,
    SEL_LEVELS
  } reg_sel_e;

  // Bank index of an address inside the register window (wraps modulo 4096).
  function automatic logic [IDX_W-1:0] bank_index(input logic [WIN_W-1:0] addr);
    logic [WIN_W-1:0] diff;
    diff = addr - WIN_BASE;
    return diff[WIN_W-1:4];
  endfunction

  // Register selected by the low nibble; valid is cleared for unused offsets.
  function automatic logic [2:0] nibble_decode(input logic [3:0] nib);
    case (nib)
      4'h0:    return {1'b1, SEL_EVENTS};
      4'h4:    return {1'b1, SEL_MASK};
      4'h8:    return {1'b1, SEL_ACK};
      4'hC:    return {1'b1, SEL_LEVELS};
      default: return {1'b0, SEL_EVENTS};
    endcase
  endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode #(
  parameter int NUM_BANKS = 2
) (
  input  logic [11:0]           addr,
  output logic                  hit,
  output logic [NUM_BANKS-1:0]  bank_oh,
  output irqc_pkg::reg_sel_e    sel
);
  import irqc_pkg::*;

  localparam logic [IDX_W-1:0] NB_LIM = IDX_W'(NUM_BANKS);

  logic [IDX_W-1:0] idx;
  logic [2:0]       nib_res;
  logic             nib_ok;

  always_comb begin
    idx     = bank_index(addr);
    nib_res = nibble_decode(addr[3:0]);
    nib_ok  = nib_res[2];
    sel     = reg_sel_e'(nib_res[1:0]);
    hit     = nib_ok && (idx < NB_LIM);
    bank_oh = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit && (idx == IDX_W'(b))) bank_oh[b] = 1'b1;
    end
  end

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int                BANK_W    = 32,
  parameter logic [BANK_W-1:0] LEVEL_SEL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] line_in,
  input  logic              mask_we,
  input  logic              ack_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] ev_q,
  output logic [BANK_W-1:0] mask_q,
  output logic [BANK_W-1:0] lv_q,
  output logic [BANK_W-1:0] rise,
  output logic [BANK_W-1:0] pend_q,
  output logic              any_next
);

  function automatic logic [BANK_W-1:0] pending_of(
    input logic [BANK_W-1:0] ev,
    input logic [BANK_W-1:0] lv,
    input logic [BANK_W-1:0] msk
  );
    return (ev | (lv & LEVEL_SEL)) & msk;
  endfunction

  logic [BANK_W-1:0] ev_d, mask_d, lv_d, ack_clr;

  always_comb begin
    rise    = line_in & ~lv_q;
    ack_clr = ack_we ? (wdata & ~LEVEL_SEL) : '0;
    // A fresh edge is applied after the acknowledge clear, so it survives.
    ev_d    = (ev_q & ~ack_clr) | (rise & ~LEVEL_SEL);
    mask_d  = mask_we ? wdata : mask_q;
    lv_d    = line_in;
    pend_q  = pending_of(ev_q, lv_q, mask_q);
    any_next = |pending_of(ev_d, lv_d, mask_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q   <= '0;
      mask_q <= '0;
      lv_q   <= '0;
    end else begin
      ev_q   <= ev_d;
      mask_q <= mask_d;
      lv_q   <= lv_d;
    end
  end

endmodule

// File: rtl/irqc_irq_out.sv
module irqc_irq_out #(
  parameter int NUM_BANKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_any_next,
  output logic                 cpu_irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_irq <= 1'b0;
    else        cpu_irq <= |bank_any_next;
  end

endmodule

// File: rtl/irqc_dual_bank.sv
module irqc_dual_bank #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter logic [NUM_BANKS*BANK_W-1:0] LEVEL_SEL = {32'h1FF0_0000, 32'h0000_0000}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] irq_lines,
  input  logic [11:0]                 reg_addr,
  input  logic                        reg_wr,
  input  logic [BANK_W-1:0]           reg_wdata,
  output logic [BANK_W-1:0]           reg_rdata,
  output logic                        cpu_irq
);
  import irqc_pkg::*;

  // Named internal wires, observed by the bound checker.
  logic                              dec_hit;
  logic [NUM_BANKS-1:0]              bank_oh;
  reg_sel_e                          dec_sel;
  logic [NUM_BANKS-1:0]              mask_hit, ack_hit, any_next;
  logic [NUM_BANKS-1:0][BANK_W-1:0]  bank_lines, ev_all, mask_all, lv_all, rise_all, pend_all;

  irqc_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .addr    (reg_addr),
    .hit     (dec_hit),
    .bank_oh (bank_oh),
    .sel     (dec_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    // Reverse order: the lowest line numbers feed the highest bank.
    assign bank_lines[b] = irq_lines[(NUM_BANKS-1-b)*BANK_W +: BANK_W];
    assign mask_hit[b]   = reg_wr && bank_oh[b] && (dec_sel == SEL_MASK);
    assign ack_hit[b]    = reg_wr && bank_oh[b] && (dec_sel == SEL_ACK);

    irqc_bank #(
      .BANK_W    (BANK_W),
      .LEVEL_SEL (LEVEL_SEL[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (bank_lines[b]),
      .mask_we  (mask_hit[b]),
      .ack_we   (ack_hit[b]),
      .wdata    (reg_wdata),
      .ev_q     (ev_all[b]),
      .mask_q   (mask_all[b]),
      .lv_q     (lv_all[b]),
      .rise     (rise_all[b]),
      .pend_q   (pend_all[b]),
      .any_next (any_next[b])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_oh[b]) begin
        case (dec_sel)
          SEL_EVENTS: reg_rdata = ev_all[b];
          SEL_MASK:   reg_rdata = mask_all[b];
          SEL_LEVELS: reg_rdata = lv_all[b];
          default:    reg_rdata = '0;
        endcase
      end
    end
  end

  irqc_irq_out #(.NUM_BANKS(NUM_BANKS)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .bank_any_next (any_next),
    .cpu_irq       (cpu_irq)
  );

endmodule

// File: rtl/irqc_dual_bank_chk.sv
module irqc_dual_bank_chk #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter logic [NUM_BANKS*BANK_W-1:0] LEVEL_SEL = '0
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [BANK_W-1:0]                 reg_wdata,
  input logic [BANK_W-1:0]                 reg_rdata,
  input logic                              cpu_irq,
  input logic                              dec_hit,
  input logic [NUM_BANKS-1:0]              mask_hit,
  input logic [NUM_BANKS-1:0]              ack_hit,
  input logic [NUM_BANKS-1:0][BANK_W-1:0]  bank_lines,
  input logic [NUM_BANKS-1:0][BANK_W-1:0]  ev_all,
  input logic [NUM_BANKS-1:0][BANK_W-1:0]  mask_all,
  input logic [NUM_BANKS-1:0][BANK_W-1:0]  lv_all,
  input logic [NUM_BANKS-1:0][BANK_W-1:0]  rise_all,
  input logic [NUM_BANKS-1:0][BANK_W-1:0]  pend_all
);

  // R3
  oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_hit |-> reg_rdata == '0);

  // R10
  irq_tracks_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cpu_irq == (|pend_all));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    localparam logic [BANK_W-1:0] LT = LEVEL_SEL[b*BANK_W +: BANK_W];

    // R7
    level_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_all[b] & LT) == '0);

    // R11
    mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_hit[b] |=> mask_all[b] == $past(reg_wdata));

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit[b] |=> (ev_all[b] & $past(reg_wdata & ~rise_all[b])) == '0);

    // R9
    edge_sets_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rise_all[b] & ~LT)) |=>
        (ev_all[b] & $past(rise_all[b] & ~LT)) == $past(rise_all[b] & ~LT));

    // R5
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> lv_all[b] == $past(bank_lines[b]));
  end

endmodule

bind irqc_dual_bank irqc_dual_bank_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W),
  .LEVEL_SEL (LEVEL_SEL)
) u_chk (.*);

// File: tb/irqc_dual_bank_tb.sv
`timescale 1ns/1ps
module irqc_dual_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_lines = '0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq;

  always #5 clk = ~clk;

  irqc_dual_bank u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cpu_irq   (cpu_irq)
  );

  // ---------------- behavioural reference ----------------
  bit [31:0] m_ev [2];
  bit [31:0] m_mask [2];
  bit [31:0] m_lv [2];
  bit        m_irq;
  bit [31:0] nl [2];
  bit [31:0] rs;
  int        bn;

  function automatic bit [31:0] lt_of(int b);
    return (b == 1) ? 32'h1FF0_0000 : 32'h0;
  endfunction

  function automatic int bank_of_addr(logic [11:0] a);
    int n;
    if (a < 12'h010) return -1;
    n = (int'(a) - 16) / 16;
    return (n < 2) ? n : -1;
  endfunction

  function automatic bit [31:0] m_read(logic [11:0] a);
    int b;
    b = bank_of_addr(a);
    if (b < 0) return 0;
    if (a[3:0] == 4'h0) return m_ev[b];
    if (a[3:0] == 4'h4) return m_mask[b];
    if (a[3:0] == 4'hC) return m_lv[b];
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin m_ev[b] = 0; m_mask[b] = 0; m_lv[b] = 0; end
      m_irq = 0;
    end else begin
      for (int k = 0; k < 64; k++) nl[1 - k / 32][k % 32] = irq_lines[k];
      bn = bank_of_addr(reg_addr);
      m_irq = 0;
      for (int b = 0; b < 2; b++) begin
        rs = nl[b] & ~m_lv[b];
        if (reg_wr && bn == b && reg_addr[3:0] == 4'h8) m_ev[b] &= ~(reg_wdata & ~lt_of(b));
        m_ev[b] |= rs & ~lt_of(b);
        if (reg_wr && bn == b && reg_addr[3:0] == 4'h4) m_mask[b] = reg_wdata;
        m_lv[b] = nl[b];
        if (((m_ev[b] | (m_lv[b] & lt_of(b))) & m_mask[b]) != 0) m_irq = 1;
      end
    end
  end

  // ---------------- comparison ----------------
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    armed = 0;
  string cur_req = "R1";

  always @(negedge clk) begin
    if (armed) begin
      #1;
      n_cmp++;
      if (cpu_irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s cpu_irq actual=%0b expected=%0b t=%0t", cur_req, cpu_irq, m_irq, $time);
      end
      n_cmp++;
      if (reg_rdata !== m_read(reg_addr)) begin
        n_bad++;
        $display("FAIL %s rdata@%h actual=%h expected=%h t=%0t", cur_req, reg_addr, reg_rdata,
                 m_read(reg_addr), $time);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #2;
    n_cmp++;
    if (reg_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s read@%h actual=%h expected=%h", tag, a, reg_addr == a ? reg_rdata : 32'hx, exp);
    end
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    #2;
    n_cmp++;
    if (cpu_irq !== exp) begin
      n_bad++;
      $display("FAIL %s cpu_irq actual=%0b expected=%0b", tag, cpu_irq, exp);
    end
  endtask

  task automatic finish_up;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    armed = 1;
    step(1);
    // R1: reset state
    cur_req = "R1";
    expect_rd(12'h010, 0, "R1"); expect_rd(12'h014, 0, "R1"); expect_rd(12'h01C, 0, "R1");
    expect_rd(12'h020, 0, "R1"); expect_rd(12'h024, 0, "R1"); expect_rd(12'h02C, 0, "R1");
    expect_irq(1'b0, "R1");

    // R11 / R2: mask write and read-back in both banks
    cur_req = "R11";
    wr(12'h014, 32'hA5A5_0F0F);
    wr(12'h024, 32'hFFFF_FFFF);
    expect_rd(12'h014, 32'hA5A5_0F0F, "R11");
    expect_rd(12'h024, 32'hFFFF_FFFF, "R2");
    wr(12'h014, 32'hFFFF_FFFF);

    // R4 / R6 / R10: line 0 edge lands in bank 1 bit 0
    cur_req = "R4";
    step(1); irq_lines[0] = 1'b1;
    step(1);
    expect_rd(12'h020, 32'h1, "R4");
    expect_irq(1'b1, "R10");
    // R8 / R6: acknowledge while held high does not retrigger
    cur_req = "R6";
    wr(12'h028, 32'h1);
    step(2);
    expect_rd(12'h020, 32'h0, "R6");
    expect_rd(12'h02C, 32'h1, "R5");
    expect_irq(1'b0, "R8");
    irq_lines[0] = 1'b0;

    // R4: line 40 lands in bank 0 bit 8
    cur_req = "R4";
    step(1); irq_lines[40] = 1'b1;
    step(1); irq_lines[40] = 1'b0;
    step(1);
    expect_rd(12'h010, 32'h100, "R4");
    expect_rd(12'h01C, 32'h0, "R6");
    // R8: ack other bits leaves bit 8
    cur_req = "R8";
    wr(12'h018, 32'hFFFF_FEFF);
    expect_rd(12'h010, 32'h100, "R8");
    wr(12'h018, 32'h100);
    expect_rd(12'h010, 32'h0, "R8");

    // R7: level line 20 (bank 1 bit 20)
    cur_req = "R7";
    step(1); irq_lines[20] = 1'b1;
    step(1);
    expect_rd(12'h020, 32'h0, "R7");
    expect_rd(12'h02C, 32'h0010_0000, "R7");
    expect_irq(1'b1, "R7");
    wr(12'h028, 32'h0010_0000);
    expect_irq(1'b1, "R7");
    irq_lines[20] = 1'b0;
    step(1);
    expect_irq(1'b0, "R7");

    // R9: edge coincides with acknowledge on bank 1 bit 1
    cur_req = "R9";
    irq_lines[1] = 1'b1; step(1); irq_lines[1] = 1'b0; step(1);
    expect_rd(12'h020, 32'h2, "R6");
    @(negedge clk);
    irq_lines[1] = 1'b1; reg_addr = 12'h028; reg_wdata = 32'h2; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    expect_rd(12'h020, 32'h2, "R9");
    irq_lines[1] = 1'b0;
    wr(12'h028, 32'h2);

    // R3: out-of-range and unused offsets
    cur_req = "R3";
    wr(12'h034, 32'h0); wr(12'h004, 32'h0); wr(12'h018 + 12'h2, 32'h0); wr(12'h010, 32'hFFFF_FFFF);
    expect_rd(12'h014, 32'hFFFF_FFFF, "R3");
    expect_rd(12'h024, 32'hFFFF_FFFF, "R3");
    expect_rd(12'h034, 32'h0, "R3");
    expect_rd(12'h004, 32'h0, "R3");
    expect_rd(12'h028, 32'h0, "R3");
    expect_rd(12'h012, 32'h0, "R3");

    // R10: masked event does not raise the output
    cur_req = "R10";
    wr(12'h024, 32'h0);
    irq_lines[5] = 1'b1; step(1);
    expect_rd(12'h020, 32'h20, "R10");
    expect_irq(1'b0, "R10");
    wr(12'h024, 32'h20);
    expect_irq(1'b1, "R10");
    irq_lines[5] = 1'b0;

    // Random mixed phase
    cur_req = "R10";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      irq_lines = irq_lines ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      case ($urandom % 10)
        0: reg_addr = 12'h010; 1: reg_addr = 12'h014; 2: reg_addr = 12'h018;
        3: reg_addr = 12'h01C; 4: reg_addr = 12'h020; 5: reg_addr = 12'h024;
        6: reg_addr = 12'h028; 7: reg_addr = 12'h02C; 8: reg_addr = 12'h030;
        default: reg_addr = 12'($urandom);
      endcase
      reg_wdata = $urandom;
      reg_wr = ($urandom % 3) == 0;
    end
    @(negedge clk); reg_wr = 1'b0;
    step(2);
    finish_up();
  end

endmodule